// File: doc/BRIEF.md
# Dual-Loop Synthesizer Word Loader

This block turns a channel number into the four 22-bit control words that configure a dual-loop (RF and IF) frequency synthesizer, and shifts them out over a serial clock, data and latch-enable trio. The RF local oscillator sits one fixed IF (280 MHz) below the channel frequency. The IF loop runs at twice the IF. Both loops use a 44 MHz reference divided by 44, which gives a 1 MHz comparison step. The divide-by-32 RF and divide-by-16 IF prescalers set how each loop's divide count is split into a swallow count A and a main count B.

A single-cycle `start` pulse captures the channel. If the channel is legal, the block raises `busy` and sends the words in a fixed order. Each word goes out most-significant bit first and is followed by a latch pulse. When the last latch pulse ends, `done` pulses for one cycle. A second device shares the clock and data wires, so its active-low select is held inactive at all times. An illegal channel produces a one-cycle error pulse, and nothing is sent.

Top module: `synth_word_loader`

## Requirements
- R1: A channel c in 1..13 gives an RF oscillator target LO = 2132 + 5·(c−1) MHz; the RF counts are A = LO mod 32 and B = LO div 32.
- R2: The RF N word has bit0 = 1, bit1 = 1, bits[8:2] = A, bits[19:9] = B, bit20 = 0 (divide-by-32) and bit21 = 0 (powered).
- R3: The IF N word has bit0 = 1, bit1 = 0, bits[8:2] = 0, bits[19:9] = 35, bit20 = 1 (divide-by-16) and bit21 = 0.
- R4: Both reference words carry bits[15:2] = 44, bit16 = 1 and bits[21:18] = 0. The IF word has bit1:bit0 = 00 and bit17 = 0; the RF word has bit1:bit0 = 10 and bit17 = 1.
- R5: Words go out in the order IF reference, IF N, RF reference, RF N. Each bit occupies one serial period, starting with bit21 and ending with bit0. In each period the clock is low for HALF_DIV cycles and then high for HALF_DIV cycles, so data changes only while the clock is low.
- R6: After bit0 of every word, the latch output is high for exactly 2·HALF_DIV cycles, with the clock and data low.
- R7: The shared device's select output is high from reset onward.
- R8: `busy` is high from the cycle after an accepted start through the last latch cycle. `done` is high for exactly the one cycle that follows.
- R9: A start with channel 0, 14 or 15 raises `chan_err` for one cycle and produces no busy, clock or latch activity.
- R10: A start pulse that arrives while busy is ignored: the ongoing bit stream is unchanged.
- R11: In reset and while idle, `busy`, `done`, `chan_err`, the serial clock, data and latch are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to load the synthesizer |
| chan | input | 4 | Channel number, captured with start |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse after the last latch |
| chan_err | output | 1 | One-cycle pulse for an illegal channel |
| ser_clk | output | 1 | Serial shift clock, data taken on its rising edge |
| ser_data | output | 1 | Serial data, MSB first |
| ser_le | output | 1 | Latch enable pulse after each word |
| peer_cs_n | output | 1 | Active-low select of the other bus device, held high |

## Verification
The assertions assume that `start` is a clean single-cycle pulse, that `chan` is valid in the cycle `start` is sampled, and that reset is applied before the first request. The stimulus changes inputs only on falling clock edges and clears `start` after one cycle. During one transfer it raises `start` with a different channel to exercise the ignore rule. The reference model rebuilds every word from the channel formula and the field positions in the requirements. It then predicts the clock, data, latch and busy levels for every cycle of a transfer.

// File: rtl/swl_pkg.sv
package swl_pkg;
  localparam int WORD_W  = 22;
  localparam int R_W     = 14;
  localparam int A_W     = 7;
  localparam int B_W     = 11;
  localparam int FREQ_W  = 12;
  localparam int NWORD   = 4;

  // field positions inside a word (bit0 leaves last)
  localparam int POS_C1  = 0;
  localparam int POS_C2  = 1;
  localparam int POS_FLD = 2;
  localparam int POS_B   = POS_FLD + A_W;
  localparam int POS_PRE = POS_B + B_W;
  localparam int POS_PWR = POS_PRE + 1;
  localparam int POS_POL = POS_FLD + R_W;
  localparam int POS_CUR = POS_POL + 1;

  typedef logic [WORD_W-1:0] word_t;

  function automatic word_t pack_ref(input logic c1, input logic c2,
                                     input logic [R_W-1:0] r,
                                     input logic pol, input logic cur);
    word_t w;
    w = '0;
    w[POS_C1] = c1;
    w[POS_C2] = c2;
    w[POS_FLD +: R_W] = r;
    w[POS_POL] = pol;
    w[POS_CUR] = cur;
    return w;
  endfunction

  function automatic word_t pack_cnt(input logic c1, input logic c2,
                                     input logic [A_W-1:0] a,
                                     input logic [B_W-1:0] b,
                                     input logic pre_small, input logic pdn);
    word_t w;
    w = '0;
    w[POS_C1] = c1;
    w[POS_C2] = c2;
    w[POS_FLD +: A_W] = a;
    w[POS_B +: B_W] = b;
    w[POS_PRE] = pre_small;
    w[POS_PWR] = pdn;
    return w;
  endfunction
endpackage

// File: rtl/swl_lo_split.sv
module swl_lo_split
  import swl_pkg::*;
#(
  parameter int PRE_LOG2 = 5
) (
  input  logic [FREQ_W-1:0] lo_mhz,
  output logic [A_W-1:0]    cnt_a,
  output logic [B_W-1:0]    cnt_b
);
  localparam int SHIFT = PRE_LOG2;
  logic [FREQ_W-1:0] quot;
  logic [FREQ_W-1:0] rem;

  always_comb begin
    quot  = lo_mhz >> SHIFT;
    rem   = lo_mhz & FREQ_W'((1 << SHIFT) - 1);
    cnt_a = A_W'(rem);
    cnt_b = B_W'(quot);
  end
endmodule

// File: rtl/swl_word_pack.sv
module swl_word_pack
  import swl_pkg::*;
#(
  parameter int R_DIV = 44
) (
  input  logic [A_W-1:0] rf_a,
  input  logic [B_W-1:0] rf_b,
  input  logic [A_W-1:0] if_a,
  input  logic [B_W-1:0] if_b,
  output word_t          words [NWORD]
);
  localparam logic [R_W-1:0] RVAL = R_W'(R_DIV);

  // slot order: IF ref, IF N, RF ref, RF N
  genvar g;
  generate
    for (g = 0; g < NWORD; g++) begin : g_slot
      localparam bit IS_RF  = (g >= 2);
      localparam bit IS_CNT = (g % 2) == 1;
      if (IS_CNT) begin : g_cnt
        assign words[g] = IS_RF ? pack_cnt(1'b1, 1'b1, rf_a, rf_b, 1'b0, 1'b0)
                                : pack_cnt(1'b1, 1'b0, if_a, if_b, 1'b1, 1'b0);
      end else begin : g_ref
        assign words[g] = pack_ref(1'b0, IS_RF, RVAL, 1'b1, IS_RF);
      end
    end
  endgenerate
endmodule

// File: rtl/synth_word_loader.sv
module synth_word_loader
  import swl_pkg::*;
#(
  parameter int HALF_DIV = 5,
  parameter int NUM_CHAN = 13,
  parameter int BASE_MHZ = 2412,
  parameter int STEP_MHZ = 5,
  parameter int IF_MHZ   = 280,
  parameter int R_DIV    = 44,
  parameter int RF_PRE_LOG2 = 5,
  parameter int IF_PRE_LOG2 = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [3:0] chan,
  output logic       busy,
  output logic       done,
  output logic       chan_err,
  output logic       ser_clk,
  output logic       ser_data,
  output logic       ser_le,
  output logic       peer_cs_n
);
  localparam int PERIOD  = 2 * HALF_DIV;
  localparam int CNT_W   = $clog2(PERIOD);
  localparam int LE_SLOT = WORD_W;
  localparam int SLOT_W  = $clog2(WORD_W + 1);
  localparam int WIDX_W  = $clog2(NWORD);
  localparam int LO0_MHZ = BASE_MHZ - IF_MHZ;
  localparam int IF_LO   = 2 * IF_MHZ;

  typedef enum logic {ST_IDLE, ST_RUN} st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt, ncnt;
  logic [SLOT_W-1:0] slot, nslot;
  logic [WIDX_W-1:0] widx, nwidx;
  word_t             words_q [NWORD];
  word_t             words_d [NWORD];
  logic              chan_ok, last_cnt, fin, nbit, nclk;
  logic [FREQ_W-1:0] rf_lo, if_lo;
  logic [A_W-1:0]    rf_a, if_a;
  logic [B_W-1:0]    rf_b, if_b;

  always_comb begin
    chan_ok = (chan != 4'd0) && (int'(chan) <= NUM_CHAN);
    rf_lo   = FREQ_W'(LO0_MHZ) + FREQ_W'(STEP_MHZ) * (FREQ_W'(chan) - FREQ_W'(1));
    if_lo   = FREQ_W'(IF_LO);
  end

  swl_lo_split #(.PRE_LOG2(RF_PRE_LOG2)) u_rf_split (
    .lo_mhz(rf_lo), .cnt_a(rf_a), .cnt_b(rf_b));
  swl_lo_split #(.PRE_LOG2(IF_PRE_LOG2)) u_if_split (
    .lo_mhz(if_lo), .cnt_a(if_a), .cnt_b(if_b));

  swl_word_pack #(.R_DIV(R_DIV)) u_pack (
    .rf_a(rf_a), .rf_b(rf_b), .if_a(if_a), .if_b(if_b), .words(words_d));

  // next position in the bit stream
  always_comb begin
    last_cnt = (cnt == CNT_W'(PERIOD - 1));
    ncnt     = last_cnt ? '0 : cnt + CNT_W'(1);
    nslot    = slot;
    nwidx    = widx;
    if (last_cnt) begin
      if (slot == SLOT_W'(LE_SLOT)) begin
        nslot = '0;
        nwidx = widx + WIDX_W'(1);
      end else begin
        nslot = slot + SLOT_W'(1);
      end
    end
    fin  = last_cnt && (slot == SLOT_W'(LE_SLOT)) && (widx == WIDX_W'(NWORD - 1));
    nbit = 1'b0;
    if (nslot != SLOT_W'(LE_SLOT))
      nbit = words_q[nwidx][WORD_W - 1 - int'(nslot)];
    nclk = (nslot != SLOT_W'(LE_SLOT)) && (ncnt >= CNT_W'(HALF_DIV));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      slot     <= '0;
      widx     <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      chan_err <= 1'b0;
      ser_clk  <= 1'b0;
      ser_data <= 1'b0;
      ser_le   <= 1'b0;
      for (int i = 0; i < NWORD; i++) words_q[i] <= '0;
    end else begin
      done     <= 1'b0;
      chan_err <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start && chan_ok) begin
            st       <= ST_RUN;
            cnt      <= '0;
            slot     <= '0;
            widx     <= '0;
            busy     <= 1'b1;
            ser_clk  <= 1'b0;
            ser_le   <= 1'b0;
            ser_data <= words_d[0][WORD_W-1];
            for (int i = 0; i < NWORD; i++) words_q[i] <= words_d[i];
          end else if (start) begin
            chan_err <= 1'b1;
          end
        end
        ST_RUN: begin
          if (fin) begin
            st       <= ST_IDLE;
            busy     <= 1'b0;
            done     <= 1'b1;
            ser_clk  <= 1'b0;
            ser_data <= 1'b0;
            ser_le   <= 1'b0;
          end else begin
            cnt      <= ncnt;
            slot     <= nslot;
            widx     <= nwidx;
            ser_clk  <= nclk;
            ser_data <= nbit;
            ser_le   <= (nslot == SLOT_W'(LE_SLOT));
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign peer_cs_n = 1'b1;
endmodule

// File: rtl/swl_chk.sv
module swl_chk #(
  parameter int HALF_DIV = 5
) (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic chan_err,
  input logic ser_clk,
  input logic ser_data,
  input logic ser_le
);
  logic [15:0] le_run;

  always_ff @(posedge clk) begin
    if (rst) le_run <= '0;
    else     le_run <= ser_le ? le_run + 16'd1 : 16'd0;
  end

  // R5: data held across every rising serial clock edge
  a_r5_data_setup: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_clk) |-> $stable(ser_data));

  // R6: latch pulse with clock low and exact width
  a_r6_le_clk_low: assert property (@(posedge clk) disable iff (rst)
    ser_le |-> (!ser_clk && !ser_data));
  a_r6_le_width: assert property (@(posedge clk) disable iff (rst)
    $fell(ser_le) |-> (le_run == 16'(2 * HALF_DIV)));

  // R8: done is a lone pulse that follows a busy period
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r8_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R9: an illegal channel never starts a transfer
  a_r9_err_no_busy: assert property (@(posedge clk) disable iff (rst)
    chan_err |=> !busy);

  // R11: idle lines stay quiet
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!ser_clk && !ser_le));
endmodule

bind synth_word_loader swl_chk #(.HALF_DIV(HALF_DIV)) u_swl_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .chan_err(chan_err),
  .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le));

// File: tb/tb_synth_word_loader.sv
module tb_synth_word_loader;
  localparam int H = 5;
  localparam int PER = 2 * H;
  localparam int SLOTS = 23;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [3:0] chan = 4'd0;
  logic busy, done, chan_err, ser_clk, ser_data, ser_le, peer_cs_n;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  synth_word_loader #(.HALF_DIV(H)) dut (
    .clk(clk), .rst(rst), .start(start), .chan(chan), .busy(busy),
    .done(done), .chan_err(chan_err), .ser_clk(ser_clk),
    .ser_data(ser_data), .ser_le(ser_le), .peer_cs_n(peer_cs_n));

  always #5 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // reference words, built from the formulas and field positions
  function automatic int ref_word(input int ch, input int idx);
    int lo, a, b;
    lo = 2412 + 5 * (ch - 1) - 280;   // R1
    a = lo % 32;
    b = lo / 32;
    case (idx)
      0: return (44 << 2) | (1 << 16);                               // R4 IF ref
      1: return 1 | (0 << 2) | (35 << 9) | (1 << 20);                // R3 IF N
      2: return 2 | (44 << 2) | (1 << 16) | (1 << 17);               // R4 RF ref
      default: return 3 | (a << 2) | (b << 9);                       // R2 RF N
    endcase
  endfunction

  task automatic run_xfer(input int ch, input bit poke);
    int words[4];
    int bitq[$];
    for (int w = 0; w < 4; w++) words[w] = ref_word(ch, w);
    for (int w = 0; w < 4; w++) begin
      for (int s = 21; s >= 0; s--) bitq.push_back((words[w] >> s) & 1);
      bitq.push_back(-1);  // latch slot
    end
    @(negedge clk); chan = 4'(ch); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < 4 * SLOTS * PER; k++) begin
      int sl, c, b;
      if (k > 0) @(negedge clk);
      if (poke && k == 300) begin chan = 4'd2; start = 1'b1; end  // R10
      if (poke && k == 301) start = 1'b0;
      sl = k / PER;
      c = k % PER;
      b = bitq[sl];
      chk("R8", "busy", int'(busy), 1);
      chk("R7", "peer_cs_n", int'(peer_cs_n), 1);
      if (b < 0) begin
        chk("R6", "ser_le", int'(ser_le), 1);
        chk("R6", "ser_clk", int'(ser_clk), 0);
        chk("R6", "ser_data", int'(ser_data), 0);
      end else begin
        chk("R6", "ser_le", int'(ser_le), 0);
        chk("R5", "ser_clk", int'(ser_clk), (c >= H) ? 1 : 0);
        chk(poke ? "R10" : "R5", "ser_data", int'(ser_data), b);
      end
    end
    @(negedge clk);
    chk("R8", "done", int'(done), 1);
    chk("R8", "busy_end", int'(busy), 0);
    @(negedge clk);
    chk("R8", "done_drop", int'(done), 0);
    chk("R11", "ser_clk_idle", int'(ser_clk), 0);
  endtask

  task automatic bad_chan(input int ch);
    @(negedge clk); chan = 4'(ch); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R9", "chan_err", int'(chan_err), 1);
    chk("R9", "busy", int'(busy), 0);
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      chk("R9", "quiet", int'(busy | ser_clk | ser_le | done), 0);
      chk("R9", "err_drop", int'(chan_err), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11", "reset_busy", int'(busy), 0);
    chk("R11", "reset_clk", int'(ser_clk), 0);
    chk("R11", "reset_le", int'(ser_le), 0);
    chk("R11", "reset_data", int'(ser_data), 0);
    chk("R11", "reset_done", int'(done | chan_err), 0);
    chk("R7", "reset_cs", int'(peer_cs_n), 1);
    rst = 1'b0;
    @(negedge clk);
    run_xfer(1, 1'b0);    // R1 R2 lowest channel: LO 2132
    run_xfer(13, 1'b0);   // R1 highest channel: LO 2192
    run_xfer(7, 1'b1);    // R10 start pulse mid-transfer ignored
    bad_chan(0);          // R9
    bad_chan(14);
    bad_chan(15);
    run_xfer(4, 1'b0);    // R3 R4 after error recovery
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule